// File: doc/BRIEF.md
# DC Link Voltage Reference Selector

This block sets the voltage command for the front-end rectifier in a two-stage supply. The front end regulates a DC link. An interleaved multi-level DC–DC stage then produces the output voltage from that link. The DC–DC stage carries the least inductor ripple when its duty ratio is a whole multiple of 1/6. The block therefore forms five candidate link voltages from the output voltage command: 6/5, 6/4, 6/3, 6/2 and 6 times the command. These set the duty ratio to 5/6, 4/6, 3/6, 2/6 and 1/6. The block issues the first candidate, in that order, that is not below the lowest link voltage the rectifier can hold.

All voltages are unsigned integers with the same LSB. Fractional candidates are rounded to nearest, and halves round up. Each candidate saturates at a maximum link limit. If no candidate reaches the minimum, the block issues the minimum itself and raises a flag. The result is captured only on an update strobe, which arrives at the voltage-loop rate, and is held between strobes.

Top module: `link_ref_sel`

## Requirements
- R1: Candidate k (k = 5, 4, 3, 2, 1) equals 6·V/k, rounded to nearest with halves rounding up, that is floor((12·V + k) / (2·k)). Candidates are tried in the order k = 5, 4, 3, 2, 1, and the first one that is greater than or equal to the minimum link voltage is captured.
- R2: Whenever the 6/5 candidate is at least the minimum, it is the issued command; for example V = 4200 with minimum 3300 issues 5040.
- R3: After a strobe, the command is never below the minimum that was present at that strobe. When no candidate reaches the minimum, the command equals that minimum and floor_o is 1.
- R4: Each candidate is limited to the maximum link input before the priority search. When the maximum is at least the minimum, the command never exceeds the maximum.
- R5: Between strobes, vdc_cmd_o and floor_o hold their values while the inputs change.
- R6: From reset until the first strobe, valid_o is 0, floor_o is 0, and vdc_cmd_o follows vdc_min_i.
- R7: A strobe on update_i makes valid_o 1 from the next clock. floor_o is rewritten on every strobe (1 when the result was clamped, 0 otherwise).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vout_cmd_i | input | VW | Output voltage command of the DC–DC stage |
| vdc_min_i | input | VW | Lowest link voltage the rectifier can regulate |
| vdc_max_i | input | VW | Upper limit for any link command |
| update_i | input | 1 | Capture strobe, one cycle per voltage-loop period |
| vdc_cmd_o | output | VW | Link voltage command to the rectifier loop |
| valid_o | output | 1 | A strobe has been taken since reset |
| floor_o | output | 1 | The last capture was clamped to the minimum |

## Verification
The bench builds the block with VW = 16. At this width, six times a large command overflows the word, so every candidate saturates when the maximum is set low. It also lets the reciprocal-multiply divide for the 6/5 and 6/4 terms run across the full command range. Random commands, minima and maxima cover every priority position. Directed values sit exactly on the boundary between two candidates and on the rounding thresholds. A maximum set below the minimum reaches the clamp path through saturation.

// File: rtl/link_ref_pkg.sv
package link_ref_pkg;
  localparam int unsigned NUM_CAND = 5;  // duty steps 5/6 .. 1/6
  localparam int unsigned STEPS    = 6;  // duty denominator
endpackage

// File: rtl/link_ref_cand.sv
module link_ref_cand
  import link_ref_pkg::*;
#(
  parameter int unsigned VW = 16
) (
  input  logic [VW-1:0] v_i,
  input  logic [VW-1:0] max_i,
  output logic [VW-1:0] cand_o [NUM_CAND]
);
  localparam int unsigned EW = VW + 3;   // holds 6*v
  localparam int unsigned S  = EW + 3;   // reciprocal shift, exact for divisors < 8
  localparam int unsigned PW = EW + S;

  logic [EW-1:0] six_v;
  assign six_v = EW'(v_i) * EW'(STEPS);

  for (genvar g = 0; g < NUM_CAND; g++) begin : g_cand
    localparam int unsigned K = NUM_CAND - g;
    logic [EW-1:0] raw;
    if (STEPS % K == 0) begin : g_exact
      assign raw = EW'(v_i) * EW'(STEPS / K);
    end else begin : g_recip
      // round-half-up divide by K via constant reciprocal multiply
      localparam longint unsigned M = ((64'd1 << S) + K - 1) / K;
      logic [PW-1:0] prod;
      assign prod = PW'(six_v + EW'(K / 2)) * PW'(M);
      assign raw  = EW'(prod >> S);
    end
    assign cand_o[g] = (raw > EW'(max_i)) ? max_i : raw[VW-1:0];
  end
endmodule

// File: rtl/link_ref_pick.sv
module link_ref_pick
  import link_ref_pkg::*;
#(
  parameter int unsigned VW = 16
) (
  input  logic [VW-1:0] cand_i [NUM_CAND],
  input  logic [VW-1:0] min_i,
  output logic [VW-1:0] pick_o,
  output logic          none_o
);
  always_comb begin
    pick_o = min_i;
    none_o = 1'b1;
    for (int g = 0; g < NUM_CAND; g++) begin
      if (none_o && cand_i[g] >= min_i) begin
        pick_o = cand_i[g];
        none_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/link_ref_sel.sv
module link_ref_sel
  import link_ref_pkg::*;
#(
  parameter int unsigned VW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [VW-1:0] vout_cmd_i,
  input  logic [VW-1:0] vdc_min_i,
  input  logic [VW-1:0] vdc_max_i,
  input  logic          update_i,
  output logic [VW-1:0] vdc_cmd_o,
  output logic          valid_o,
  output logic          floor_o
);
  logic [VW-1:0] cand [NUM_CAND];
  logic [VW-1:0] pick;
  logic          none;
  logic [VW-1:0] cmd_q;
  logic          valid_q, floor_q;

  link_ref_cand #(.VW(VW)) u_cand (
    .v_i(vout_cmd_i), .max_i(vdc_max_i), .cand_o(cand)
  );

  link_ref_pick #(.VW(VW)) u_pick (
    .cand_i(cand), .min_i(vdc_min_i), .pick_o(pick), .none_o(none)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      valid_q <= 1'b0;
      floor_q <= 1'b0;
    end else if (update_i) begin
      cmd_q   <= pick;
      valid_q <= 1'b1;
      floor_q <= none;
    end
  end

  // before first capture the rectifier is pointed at its own floor
  assign vdc_cmd_o = valid_q ? cmd_q : vdc_min_i;
  assign valid_o   = valid_q;
  assign floor_o   = floor_q;
endmodule

// File: rtl/link_ref_sel_chk.sv
module link_ref_sel_chk #(
  parameter int unsigned VW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [VW-1:0] vdc_min_i,
  input logic [VW-1:0] vdc_max_i,
  input logic          update_i,
  input logic [VW-1:0] vdc_cmd_o,
  input logic          valid_o,
  input logic          floor_o
);
  a_r3_not_below_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> vdc_cmd_o >= $past(vdc_min_i));

  a_r3_floor_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (!floor_o || vdc_cmd_o == $past(vdc_min_i)));

  a_r4_not_above_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && vdc_max_i >= vdc_min_i) |=> vdc_cmd_o <= $past(vdc_max_i));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !update_i) |=> ($stable(vdc_cmd_o) && $stable(floor_o)));

  a_r7_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> valid_o);

  a_r6_valid_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(update_i));
endmodule

bind link_ref_sel link_ref_sel_chk #(.VW(VW)) u_chk (.*);

// File: tb/link_ref_sel_tb.sv
module link_ref_sel_tb;
  localparam int unsigned VW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] vout, vmin, vmax;
  logic          upd = 1'b0;
  logic [VW-1:0] cmd;
  logic          valid, floor_f;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  link_ref_sel #(.VW(VW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vout_cmd_i(vout), .vdc_min_i(vmin),
    .vdc_max_i(vmax), .update_i(upd), .vdc_cmd_o(cmd), .valid_o(valid),
    .floor_o(floor_f)
  );

  function automatic void model(input longint v, input longint mn, input longint mx,
                                output longint e_cmd, output bit e_fl);
    e_fl  = 1;
    e_cmd = mn;
    for (int k = 5; k >= 1; k--) begin
      longint c = (12 * v + k) / (2 * k);
      if (c > mx) c = mx;
      if (e_fl && c >= mn) begin
        e_cmd = c;
        e_fl  = 0;
      end
    end
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input longint v, input longint mn, input longint mx, input string req);
    longint e_cmd;
    bit e_fl;
    model(v, mn, mx, e_cmd, e_fl);
    @(negedge clk);
    vout = VW'(v); vmin = VW'(mn); vmax = VW'(mx); upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    chk({req, " cmd"}, longint'(cmd), e_cmd);
    chk({req, " floor"}, longint'(floor_f), longint'(e_fl));
    chk("R7 valid", longint'(valid), 1);
  endtask

  task automatic hold_test;
    longint c0 = longint'(cmd);
    longint f0 = longint'(floor_f);
    @(negedge clk);
    vout = VW'($urandom); vmin = VW'($urandom); vmax = VW'($urandom);
    repeat (3) @(negedge clk);
    chk("R5 hold cmd", longint'(cmd), c0);
    chk("R5 hold floor", longint'(floor_f), f0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    vout = 16'd4200; vmin = 16'd3300; vmax = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R6 reset valid", longint'(valid), 0);
    chk("R6 reset floor", longint'(floor_f), 0);
    chk("R6 reset cmd", longint'(cmd), 3300);
    rst_n = 1'b1;
    @(negedge clk);
    vmin = 16'd2000;
    @(negedge clk);
    chk("R6 pre-strobe cmd follows min", longint'(cmd), 2000);
    chk("R6 pre-strobe valid", longint'(valid), 0);

    strobe(4200, 3300, 65535, "R2 6/5 preferred");
    chk("R2 fixed 504V case", longint'(cmd), 5040);
    hold_test();
    strobe(2750, 3300, 65535, "R1 equal to min");
    chk("R1 boundary pick", longint'(cmd), 3300);
    strobe(2749, 3300, 65535, "R1 falls to 6/4");
    chk("R1 6/4 pick", longint'(cmd), 4124);
    strobe(3, 0, 65535, "R1 round 3.6");
    chk("R1 rounded", longint'(cmd), 4);
    strobe(1, 2, 65535, "R1 round half up 6/4");
    strobe(100, 3300, 65535, "R3 clamp to min");
    chk("R3 floor raised", longint'(floor_f), 1);
    hold_test();
    strobe(60000, 3300, 50000, "R4 saturate");
    chk("R4 max value", longint'(cmd), 50000);
    strobe(4000, 3300, 1000, "R4 saturated below min");
    chk("R3 clamp after sat", longint'(cmd), 3300);
    strobe(0, 0, 65535, "R1 zero");
    strobe(65535, 0, 65535, "R4 full scale");

    for (int i = 0; i < 4000; i++) begin
      longint v  = longint'($urandom_range(0, 65535));
      longint mn = longint'($urandom_range(0, 65535));
      longint mx = (i % 8 == 0) ? longint'($urandom_range(0, 65535))
                                : longint'($urandom_range(int'(mn), 65535));
      strobe(v, mn, mx, "R1 random");
      if (i % 50 == 0) hold_test();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule